// File: doc/BRIEF.md
# Reset Sequencer for an 8-bit Controller

This block owns reset for a small 8-bit controller. It watches the external active-low reset pin and a request line from the internal watchdog. It decides when the chip is held in reset. On release it runs a fixed start-up routine that brings the CPU out of reset at its start address.

The block divides the system clock into a CPU clock enable, and every sequencing step advances on that enable. A low pulse on the pin counts as a reset only if it is seen on enough CPU cycles. A watchdog request is treated as a reset that is already qualified.

After release the sequencer does the following, in order:
- waits a fixed initialisation delay;
- sets the interrupt mask flag;
- reads the two bytes of the start address through a small read port and assembles them into the program counter;
- pulses `run` so the CPU begins fetching.

Until that pulse, a set of per-peripheral reset-state outputs stays asserted. These cover the I/O ports, the sync logic, the timer, the interrupts, the ADC, the display-data channel, the watchdog and the PWM channels.

Top module: `reset_sequencer`

## Requirements
- R1: `cpu_ce` is high on exactly one of every DIV (default 2) system clock cycles and is never high on two cycles in a row.
- R2: A reset from the pin takes effect only if the pin is seen low on at least MIN_LOW (default 2) consecutive CPU-cycle edges. A low pulse seen on a single CPU edge is ignored: `run` state, `pc` and the reset-state outputs are unchanged.
- R3: A one-cycle `wdt_req` pulse returns the block to the held state without any pin activity. The block then restarts the start-up routine and pulses `run` again.
- R4: `cpu_mem_inhibit` is high in the same cycle as the pin is low, and also throughout the held state.
- R5: Counting as edge 1 the first CPU edge that samples the released pin high, six initialisation cycles follow. `irq_mask` rises at edge 8.
- R6: At edge 9 the byte read from address 0xFFFC is loaded into `pc[7:0]`. At edge 10 the byte read from 0xFFFD is loaded into `pc[15:8]`. `vec_rd` is high only while one of these two addresses is on `vec_addr`.
- R7: `run` is high for exactly one system cycle, right after edge 10, and at that moment `pc` holds the assembled address.
- R8: From the held state until `run`, all reset-state outputs are asserted. `pwm_half_duty` is 0x007F (channels 0..6) and `pwm_disable` is 0x1F80 (channels 7..12). Once running, every reset-state output is 0.
- R9: A qualified reset that arrives during initialisation or the vector fetch aborts the routine. It clears `irq_mask` and `pc` and restarts the full timing on the next release.
- R10: In the held state, `pc` is 0 and `irq_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset of the sequencer itself, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, already noise-filtered |
| wdt_req | input | 1 | Watchdog reset request, one system-cycle pulse |
| vec_rdata | input | 8 | Read data returned for `vec_addr` within the same CPU cycle |
| cpu_ce | output | 1 | CPU clock enable |
| cpu_mem_inhibit | output | 1 | Blocks CPU memory reads and writes |
| irq_mask | output | 1 | Interrupt mask flag |
| pc | output | 16 | Program counter loaded from the vector |
| run | output | 1 | One-cycle pulse telling the CPU to start at `pc` |
| vec_rd | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector read address |
| io_force_high | output | 1 | Ports act as outputs driven high |
| sync_clr | output | 1 | Clear sync counters and H/V count latches |
| sync_out_off | output | 1 | Disable sync outputs |
| tmr_clr | output | 1 | Disable and clear the base timer |
| irq_clr | output | 1 | Disable and clear all interrupt sources |
| adc_stop | output | 1 | Disable and stop the ADC |
| ddc_off | output | 1 | Disable the display-data channel |
| wdt_clr | output | 1 | Clear the watchdog, leaving it enabled |
| pwm_half_duty | output | 13 | Per channel: force a 50% duty output |
| pwm_disable | output | 13 | Per channel: disable output |

## Verification
Pin pulses are applied with lengths either side of the qualification threshold. A pulse seen on one CPU edge must leave a running CPU untouched, while one seen on two edges must hold it, which separates a correct count from an off-by-one. The release is timed edge by edge. The edges at which the mask rises and `run` pulses separate the initialisation length from the fetch length. Distinct vector bytes are used per run, so that swapped or stale bytes are caught. A watchdog pulse and a mid-initialisation pin reset each start a second full routine, which separates restart from resume.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_INIT,
        ST_MASK,
        ST_FLO,
        ST_FHI,
        ST_RUN
    } seq_st_e;
endpackage

// File: rtl/cpu_ce_div.sv
module cpu_ce_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic por_n,
    output logic ce
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_s;

    div_s div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == CW'(DIV - 1)) div_d.cnt = '0;
        else                           div_d.cnt = div_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign ce = (div_q.cnt == CW'(DIV - 1));

    // R1
    ce_spacing_chk: assert property (@(posedge clk) disable iff (!por_n)
        ce |=> !ce);
endmodule

// File: rtl/rst_qual.sv
module rst_qual #(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic ce,
    input  logic pin_n,
    input  logic wdt_req,
    output logic pin_hi,
    output logic wdt_act,
    output logic fire
);
    localparam int CW = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic          pin;
        logic [CW-1:0] cnt;
        logic          pend;
        logic          act;
    } qual_s;

    qual_s qual_d, qual_q;
    logic  qualified;

    always_comb begin
        qual_d      = qual_q;
        qual_d.pin  = pin_n;
        qual_d.pend = qual_q.pend | wdt_req;
        if (ce) begin
            qual_d.act  = qual_q.pend | wdt_req;
            qual_d.pend = 1'b0;
            if (qual_q.pin)                       qual_d.cnt = '0;
            else if (qual_q.cnt != CW'(MIN_LOW))  qual_d.cnt = qual_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            qual_q.pin  <= 1'b0;
            qual_q.cnt  <= CW'(MIN_LOW);
            qual_q.pend <= 1'b0;
            qual_q.act  <= 1'b0;
        end else begin
            qual_q <= qual_d;
        end
    end

    assign qualified = (qual_q.cnt == CW'(MIN_LOW));
    assign pin_hi    = qual_q.pin;
    assign wdt_act   = qual_q.act;
    assign fire      = qualified | qual_q.act;

    // R2
    pin_high_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ce && pin_hi) |=> !qualified);

    // R3
    wdt_reaches_act_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ce && qual_q.pend) |=> wdt_act);
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
    import rseq_pkg::*;
#(
    parameter int               INIT_CYCLES = 6,
    parameter logic [ADDR_W-1:0] VEC_LO     = 16'hFFFC
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ce,
    input  logic              pin_hi,
    input  logic              wdt_act,
    input  logic              fire,
    input  logic [DATA_W-1:0] vec_rdata,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] pc,
    output logic              irq_mask,
    output logic              run,
    output logic              in_reset,
    output logic              hold
);
    localparam int CW = (INIT_CYCLES > 2) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [ADDR_W-1:0] VEC_HI = VEC_LO + ADDR_W'(1);

    typedef struct packed {
        seq_st_e           st;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] pc;
        logic              mask;
        logic              run;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.run = 1'b0;
        if (ce) begin
            if (fsm_q.st != ST_HOLD && fire) begin
                fsm_d.st   = ST_HOLD;
                fsm_d.cnt  = '0;
                fsm_d.pc   = '0;
                fsm_d.mask = 1'b0;
            end else begin
                unique case (fsm_q.st)
                    ST_HOLD: begin
                        fsm_d.pc   = '0;
                        fsm_d.mask = 1'b0;
                        fsm_d.cnt  = '0;
                        if (pin_hi && !wdt_act) fsm_d.st = ST_INIT;
                    end
                    ST_INIT: begin
                        if (fsm_q.cnt == CW'(INIT_CYCLES - 1)) begin
                            fsm_d.st  = ST_MASK;
                            fsm_d.cnt = '0;
                        end else begin
                            fsm_d.cnt = fsm_q.cnt + CW'(1);
                        end
                    end
                    ST_MASK: begin
                        fsm_d.mask = 1'b1;
                        fsm_d.st   = ST_FLO;
                    end
                    ST_FLO: begin
                        fsm_d.pc[DATA_W-1:0] = vec_rdata;
                        fsm_d.st             = ST_FHI;
                    end
                    ST_FHI: begin
                        fsm_d.pc[ADDR_W-1:DATA_W] = vec_rdata;
                        fsm_d.st                  = ST_RUN;
                        fsm_d.run                 = 1'b1;
                    end
                    ST_RUN: ;
                    default: fsm_d.st = ST_HOLD;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fsm_q.st   <= ST_HOLD;
            fsm_q.cnt  <= '0;
            fsm_q.pc   <= '0;
            fsm_q.mask <= 1'b0;
            fsm_q.run  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign vec_rd   = (fsm_q.st == ST_FLO) || (fsm_q.st == ST_FHI);
    assign vec_addr = (fsm_q.st == ST_FHI) ? VEC_HI : VEC_LO;
    assign pc       = fsm_q.pc;
    assign irq_mask = fsm_q.mask;
    assign run      = fsm_q.run;
    assign in_reset = (fsm_q.st != ST_RUN);
    assign hold     = (fsm_q.st == ST_HOLD);

    // R5
    mask_before_fetch_chk: assert property (@(posedge clk) disable iff (!por_n)
        vec_rd |-> irq_mask);

    // R6
    vec_addr_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        vec_rd |-> (vec_addr == VEC_LO || vec_addr == VEC_HI));

    // R7
    run_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        run |=> !run);

    // R7
    run_after_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
        run |-> (irq_mask && !in_reset));

    // R9
    abort_to_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ce && fire && !hold) |=> (hold && !irq_mask && pc == '0));

    // R10
    hold_clean_chk: assert property (@(posedge clk) disable iff (!por_n)
        hold |-> (pc == '0 && !irq_mask));
endmodule

// File: rtl/rst_fanout.sv
module rst_fanout #(
    parameter int N_PWM  = 13,
    parameter int N_HALF = 7
) (
    input  logic             in_reset,
    output logic             io_force_high,
    output logic             sync_clr,
    output logic             sync_out_off,
    output logic             tmr_clr,
    output logic             irq_clr,
    output logic             adc_stop,
    output logic             ddc_off,
    output logic             wdt_clr,
    output logic [N_PWM-1:0] pwm_half_duty,
    output logic [N_PWM-1:0] pwm_disable
);
    assign io_force_high = in_reset;
    assign sync_clr      = in_reset;
    assign sync_out_off  = in_reset;
    assign tmr_clr       = in_reset;
    assign irq_clr       = in_reset;
    assign adc_stop      = in_reset;
    assign ddc_off       = in_reset;
    assign wdt_clr       = in_reset;

    for (genvar ch = 0; ch < N_PWM; ch++) begin : g_pwm
        if (ch < N_HALF) begin : g_half
            assign pwm_half_duty[ch] = in_reset;
            assign pwm_disable[ch]   = 1'b0;
        end else begin : g_off
            assign pwm_half_duty[ch] = 1'b0;
            assign pwm_disable[ch]   = in_reset;
        end
    end

    // R8
    always_comb begin
        pwm_exclusive_chk: assert ((pwm_half_duty & pwm_disable) == '0);
    end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rseq_pkg::*;
#(
    parameter int                DIV         = 2,
    parameter int                MIN_LOW     = 2,
    parameter int                INIT_CYCLES = 6,
    parameter int                N_PWM       = 13,
    parameter int                N_HALF      = 7,
    parameter logic [ADDR_W-1:0] VEC_LO      = 16'hFFFC
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_n,
    input  logic              wdt_req,
    input  logic [DATA_W-1:0] vec_rdata,
    output logic              cpu_ce,
    output logic              cpu_mem_inhibit,
    output logic              irq_mask,
    output logic [ADDR_W-1:0] pc,
    output logic              run,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              io_force_high,
    output logic              sync_clr,
    output logic              sync_out_off,
    output logic              tmr_clr,
    output logic              irq_clr,
    output logic              adc_stop,
    output logic              ddc_off,
    output logic              wdt_clr,
    output logic [N_PWM-1:0]  pwm_half_duty,
    output logic [N_PWM-1:0]  pwm_disable
);
    logic pin_hi;
    logic wdt_act;
    logic fire;
    logic in_reset;
    logic hold;

    cpu_ce_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .por_n (por_n),
        .ce    (cpu_ce)
    );

    rst_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk     (clk),
        .por_n   (por_n),
        .ce      (cpu_ce),
        .pin_n   (rst_pin_n),
        .wdt_req (wdt_req),
        .pin_hi  (pin_hi),
        .wdt_act (wdt_act),
        .fire    (fire)
    );

    boot_fsm #(.INIT_CYCLES(INIT_CYCLES), .VEC_LO(VEC_LO)) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .ce        (cpu_ce),
        .pin_hi    (pin_hi),
        .wdt_act   (wdt_act),
        .fire      (fire),
        .vec_rdata (vec_rdata),
        .vec_rd    (vec_rd),
        .vec_addr  (vec_addr),
        .pc        (pc),
        .irq_mask  (irq_mask),
        .run       (run),
        .in_reset  (in_reset),
        .hold      (hold)
    );

    rst_fanout #(.N_PWM(N_PWM), .N_HALF(N_HALF)) u_fan (
        .in_reset      (in_reset),
        .io_force_high (io_force_high),
        .sync_clr      (sync_clr),
        .sync_out_off  (sync_out_off),
        .tmr_clr       (tmr_clr),
        .irq_clr       (irq_clr),
        .adc_stop      (adc_stop),
        .ddc_off       (ddc_off),
        .wdt_clr       (wdt_clr),
        .pwm_half_duty (pwm_half_duty),
        .pwm_disable   (pwm_disable)
    );

    assign cpu_mem_inhibit = ~rst_pin_n | hold;

    // R4
    inhibit_in_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (hold || !rst_pin_n) |-> cpu_mem_inhibit);
endmodule

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
    logic        clk = 1'b0;
    logic        por_n;
    logic        rst_pin_n;
    logic        wdt_req;
    logic [7:0]  vec_rdata;
    logic        cpu_ce, cpu_mem_inhibit, irq_mask, run, vec_rd;
    logic [15:0] pc, vec_addr;
    logic        io_force_high, sync_clr, sync_out_off, tmr_clr;
    logic        irq_clr, adc_stop, ddc_off, wdt_clr;
    logic [12:0] pwm_half_duty, pwm_disable;

    logic [7:0]  mem_lo, mem_hi;
    int          n_checks = 0;
    int          n_fail   = 0;

    always #2 clk = ~clk;

    assign vec_rdata = (vec_addr == 16'hFFFC) ? mem_lo :
                       (vec_addr == 16'hFFFD) ? mem_hi : 8'hEE;

    reset_sequencer uut (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wdt_req(wdt_req),
        .vec_rdata(vec_rdata), .cpu_ce(cpu_ce), .cpu_mem_inhibit(cpu_mem_inhibit),
        .irq_mask(irq_mask), .pc(pc), .run(run), .vec_rd(vec_rd),
        .vec_addr(vec_addr), .io_force_high(io_force_high), .sync_clr(sync_clr),
        .sync_out_off(sync_out_off), .tmr_clr(tmr_clr), .irq_clr(irq_clr),
        .adc_stop(adc_stop), .ddc_off(ddc_off), .wdt_clr(wdt_clr),
        .pwm_half_duty(pwm_half_duty), .pwm_disable(pwm_disable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rst_vec();
        return {io_force_high, sync_clr, sync_out_off, tmr_clr,
                irq_clr, adc_stop, ddc_off, wdt_clr};
    endfunction

    // Returns at the falling edge just after a CPU-enable rising edge.
    task automatic next_ce();
        @(negedge clk);
        while (!cpu_ce) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Count CPU edges from release until mask rise and run pulse.
    task automatic time_boot(output int mask_at, output int run_at, output logic [15:0] pc_at_run);
        mask_at = 0; run_at = 0; pc_at_run = '0;
        for (int k = 1; k <= 20; k++) begin
            next_ce();
            if (irq_mask && mask_at == 0) mask_at = k;
            if (run && run_at == 0) begin
                run_at = k;
                pc_at_run = pc;
            end
        end
    endtask

    task automatic t_clock_enable();
        int ones = 0;
        logic prev = 1'b0;
        int doubles = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cpu_ce) ones++;
            if (cpu_ce && prev) doubles++;
            prev = cpu_ce;
        end
        check("R1 ce count", ones, 10);
        check("R1 ce back-to-back", doubles, 0);
    endtask

    task automatic t_power_on();
        por_n = 1'b0; rst_pin_n = 1'b0; wdt_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 pc in reset", pc, 16'h0);
        check("R10 mask in reset", irq_mask, 0);
        por_n = 1'b1;
        repeat (3) next_ce();
        check("R8 reset outputs held", rst_vec(), 8'hFF);
        check("R8 pwm half in hold", pwm_half_duty, 13'h007F);
        check("R8 pwm off in hold", pwm_disable, 13'h1F80);
        check("R4 inhibit while pin low", cpu_mem_inhibit, 1);
        check("R10 pc held", pc, 16'h0);
    endtask

    task automatic t_boot(input logic [7:0] lo, input logic [7:0] hi);
        int m, r;
        logic [15:0] p;
        mem_lo = lo; mem_hi = hi;
        rst_pin_n = 1'b1;
        time_boot(m, r, p);
        check("R5 mask edge", m, 8);
        check("R7 run edge", r, 10);
        check("R6 pc assembled", p, {hi, lo});
        @(negedge clk);
        check("R7 run one cycle", run, 0);
        check("R8 outputs released", rst_vec(), 8'h00);
        check("R8 pwm released", {pwm_half_duty, pwm_disable}, 26'h0);
        check("R4 inhibit released", cpu_mem_inhibit, 0);
    endtask

    task automatic t_short_pulse();
        logic [15:0] pc_before;
        pc_before = pc;
        next_ce();
        rst_pin_n = 1'b0;
        #1;
        check("R4 inhibit same cycle", cpu_mem_inhibit, 1);
        next_ce();
        rst_pin_n = 1'b1;
        repeat (4) next_ce();
        check("R2 short pulse ignored outputs", rst_vec(), 8'h00);
        check("R2 short pulse ignored pc", pc, pc_before);
        check("R2 short pulse mask kept", irq_mask, 1);
    endtask

    task automatic t_long_pulse();
        next_ce();
        rst_pin_n = 1'b0;
        repeat (3) next_ce();
        check("R2 qualified pulse holds", rst_vec(), 8'hFF);
        check("R10 pc cleared", pc, 16'h0);
        check("R10 mask cleared", irq_mask, 0);
        t_boot(8'h5A, 8'hC3);
    endtask

    task automatic t_watchdog();
        logic saw_hold = 1'b0;
        int run_at = 0;
        logic [15:0] p = '0;
        mem_lo = 8'h11; mem_hi = 8'h9E;
        @(negedge clk);
        wdt_req = 1'b1;
        @(negedge clk);
        wdt_req = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            next_ce();
            if (sync_clr && !irq_mask) saw_hold = 1'b1;
            if (run && run_at == 0) begin
                run_at = k;
                p = pc;
            end
        end
        check("R3 watchdog reached reset", saw_hold, 1);
        check("R3 watchdog rerun", run_at != 0, 1);
        check("R3 watchdog pc", p, 16'h9E11);
    endtask

    task automatic t_abort();
        next_ce();
        rst_pin_n = 1'b0;
        repeat (3) next_ce();
        rst_pin_n = 1'b1;
        repeat (5) next_ce();
        check("R9 in init reset outputs", rst_vec(), 8'hFF);
        rst_pin_n = 1'b0;
        repeat (3) next_ce();
        check("R9 aborted mask", irq_mask, 0);
        check("R9 aborted pc", pc, 16'h0);
        t_boot(8'h34, 8'h12);
    endtask

    initial begin
        rst_pin_n = 1'b0; wdt_req = 1'b0; por_n = 1'b0;
        mem_lo = 8'h00; mem_hi = 8'h00;
        fork
            begin
                t_power_on();
                t_clock_enable();
                t_boot(8'hA7, 8'hE0);
                t_short_pulse();
                t_long_pulse();
                t_watchdog();
                t_abort();
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule